// File: doc/BRIEF.md
# Banked Memory Paging Unit

This block translates a 16-bit processor address into a physical location inside a larger RAM built from 16 KB banks. The processor address space is split into four 16 KB segments, and address bits 15..14 pick the segment. Each segment has its own paging register that is loaded by an I/O write to one of four consecutive port numbers. The register either names one bank for both reads and writes, or names two separate banks, one for reads and one for writes, drawn from the first eight banks.

A fifth port holds one flag per segment. A set flag makes reads in that segment use the segment's write bank, whatever read bank is stored. The block produces a read bank, a write bank and the two matching physical addresses `{bank, addr[13:0]}` for the current processor address. The RAM, any contention stalls and the RAM contents are outside this block.

The register interface is a plain strobe with port and data and has no back-pressure: every strobed write is taken on the clock edge where it is seen. The address-to-bank path is purely combinational from the stored state, so there is no valid/ready stream at either edge of the block.

Top module: `bank_pager`

## Requirements
- R1: After reset every segment maps bank 0 for reads and for writes, and all force-read flags are clear.
- R2: A strobed write to port 0xF0, 0xF1, 0xF2 or 0xF3 loads the register of the segment at 0x0000, 0x4000, 0x8000 or 0xC000 respectively, and address bits 15..14 select which segment's banks are driven out.
- R3: If bit 7 of the written value is 1, bits 6..0 give one bank number used for both reads and writes in that segment (for example 0x85 to port 0xF1 maps bank 5 at 0x4000, and 0xFF selects bank 127).
- R4: If bit 7 of the written value is 0, bits 2..0 give the write bank and bits 6..4 give the read bank, and bit 3 has no effect.
- R5: A strobed write to port 0xF4 loads the force-read flags from bits 7, 6, 5 and 4 for the segments at 0xC000, 0x0000, 0x8000 and 0x4000 respectively; bits 3..0 of that value have no effect.
- R6: While a segment's force-read flag is set, its read bank equals its write bank; the write bank and the stored read bank are unchanged by the flag.
- R7: The read and write physical addresses are the respective bank number concatenated above address bits 13..0.
- R8: A write to any other port, or port activity without the strobe, changes no mapping and no flag.
- R9: A strobed write changes the outputs only after the clock edge that samples it; before that edge the previous mapping is still driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | I/O write strobe, sampled on the rising clock edge |
| io_port | input | 8 | I/O port number of the write |
| io_data | input | 8 | I/O write data |
| cpu_addr | input | 16 | Processor address |
| rd_bank | output | 7 | Bank used for a read at cpu_addr |
| wr_bank | output | 7 | Bank used for a write at cpu_addr |
| rd_paddr | output | 21 | Physical read address |
| wr_paddr | output | 21 | Physical write address |

## Verification
The assertions take for granted that `io_wr`, `io_port` and `io_data` carry known values at every sampling edge once reset is released, and that `cpu_addr` is known whenever outputs are looked at. The bench drives all inputs to defined values from time zero, changes them only on the falling edge, and holds reset low for several cycles before any strobe. Random phases keep port numbers in the 0xF0 to 0xF5 range plus a few outside ports so that ignored writes are mixed with live ones.

// File: rtl/pager_pkg.sv
package pager_pkg;

  localparam int SEGS     = 4;
  localparam int SEG_W    = 2;
  localparam int DATA_W   = 8;
  localparam int SPLIT_W  = 3;
  localparam int FLAG_LSB = 4;

  typedef enum logic {
    MAP_SPLIT   = 1'b0,
    MAP_UNIFIED = 1'b1
  } map_mode_e;

  // Position inside the upper nibble of the force-port value that drives
  // the flag of each segment (this order is decoded by software).
  function automatic int flag_index(input int seg);
    case (seg)
      0:       return 2;
      1:       return 0;
      2:       return 1;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/pager_port_decode.sv
module pager_port_decode
  import pager_pkg::*;
#(
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] SEG_BASE  = 8'hF0,
  parameter logic [PORT_W-1:0] FORCE_ADR = 8'hF4
) (
  input  logic              io_wr,
  input  logic [PORT_W-1:0] io_port,
  output logic [SEGS-1:0]   seg_we,
  output logic              force_we
);

  for (genvar s = 0; s < SEGS; s++) begin : g_seg_dec
    localparam logic [PORT_W-1:0] MY_PORT = SEG_BASE + PORT_W'(s);
    assign seg_we[s] = io_wr && (io_port == MY_PORT);
  end

  assign force_we = io_wr && (io_port == FORCE_ADR);

endmodule

// File: rtl/pager_seg_reg.sv
module pager_seg_reg
  import pager_pkg::*;
#(
  parameter int BANK_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] data,
  output logic [BANK_W-1:0] rd_bank,
  output logic [BANK_W-1:0] wr_bank
);

  map_mode_e         mode;
  logic [BANK_W-1:0] nxt_rd;
  logic [BANK_W-1:0] nxt_wr;

  assign mode = map_mode_e'(data[DATA_W-1]);

  always_comb begin
    if (mode == MAP_UNIFIED) begin
      nxt_rd = BANK_W'(data[DATA_W-2:0]);
      nxt_wr = BANK_W'(data[DATA_W-2:0]);
    end else begin
      nxt_rd = BANK_W'(data[FLAG_LSB +: SPLIT_W]);
      nxt_wr = BANK_W'(data[SPLIT_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank <= '0;
      wr_bank <= '0;
    end else if (we) begin
      rd_bank <= nxt_rd;
      wr_bank <= nxt_wr;
    end
  end

  assert_unified_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && data[DATA_W-1]) |=> (rd_bank == wr_bank));

  assert_split_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !data[DATA_W-1]) |=> ((rd_bank < BANK_W'(8)) && (wr_bank < BANK_W'(8))));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(rd_bank) && $stable(wr_bank)));

endmodule

// File: rtl/pager_force_reg.sv
module pager_force_reg
  import pager_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [DATA_W-FLAG_LSB-1:0] flags_in,
  output logic [SEGS-1:0]            force_seg
);

  for (genvar s = 0; s < SEGS; s++) begin : g_flag
    localparam int IDX = flag_index(s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  force_seg[s] <= 1'b0;
      else if (we) force_seg[s] <= flags_in[IDX];
    end
  end

  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(force_seg));

  assert_flag_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($countones(force_seg) == $countones($past(flags_in))));

endmodule

// File: rtl/pager_map_mux.sv
module pager_map_mux
  import pager_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           cpu_addr,
  input  logic [SEGS-1:0][BANK_W-1:0] seg_rd,
  input  logic [SEGS-1:0][BANK_W-1:0] seg_wr,
  input  logic [SEGS-1:0]             force_seg,
  output logic [BANK_W-1:0]           rd_bank,
  output logic [BANK_W-1:0]           wr_bank,
  output logic [BANK_W+ADDR_W-SEG_W-1:0] rd_paddr,
  output logic [BANK_W+ADDR_W-SEG_W-1:0] wr_paddr
);

  localparam int OFF_W = ADDR_W - SEG_W;

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] offset;

  assign seg    = cpu_addr[ADDR_W-1 -: SEG_W];
  assign offset = cpu_addr[OFF_W-1:0];

  always_comb begin
    wr_bank = seg_wr[seg];
    rd_bank = force_seg[seg] ? seg_wr[seg] : seg_rd[seg];
  end

  assign rd_paddr = {rd_bank, offset};
  assign wr_paddr = {wr_bank, offset};

  assert_force_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_seg[seg] |-> (rd_paddr == wr_paddr));

  assert_offset_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_paddr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]) && (wr_paddr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]));

endmodule

// File: rtl/bank_pager.sv
module bank_pager
  import pager_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                BANK_W    = 7,
  parameter int                PORT_W    = 8,
  parameter logic [PORT_W-1:0] SEG_BASE  = 8'hF0,
  parameter logic [PORT_W-1:0] FORCE_ADR = 8'hF4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic [PORT_W-1:0]             io_port,
  input  logic [DATA_W-1:0]             io_data,
  input  logic [ADDR_W-1:0]             cpu_addr,
  output logic [BANK_W-1:0]             rd_bank,
  output logic [BANK_W-1:0]             wr_bank,
  output logic [BANK_W+ADDR_W-SEG_W-1:0] rd_paddr,
  output logic [BANK_W+ADDR_W-SEG_W-1:0] wr_paddr
);

  logic [SEGS-1:0]             seg_we;
  logic                        force_we;
  logic [SEGS-1:0][BANK_W-1:0] seg_rd;
  logic [SEGS-1:0][BANK_W-1:0] seg_wr;
  logic [SEGS-1:0]             force_seg;

  pager_port_decode #(
    .PORT_W(PORT_W), .SEG_BASE(SEG_BASE), .FORCE_ADR(FORCE_ADR)
  ) u_decode (
    .io_wr(io_wr), .io_port(io_port), .seg_we(seg_we), .force_we(force_we)
  );

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    pager_seg_reg #(.BANK_W(BANK_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(seg_we[s]), .data(io_data),
      .rd_bank(seg_rd[s]), .wr_bank(seg_wr[s])
    );
  end

  pager_force_reg u_force (
    .clk(clk), .rst_n(rst_n), .we(force_we),
    .flags_in(io_data[DATA_W-1:FLAG_LSB]), .force_seg(force_seg)
  );

  pager_map_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
    .seg_rd(seg_rd), .seg_wr(seg_wr), .force_seg(force_seg),
    .rd_bank(rd_bank), .wr_bank(wr_bank),
    .rd_paddr(rd_paddr), .wr_paddr(wr_paddr)
  );

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seg_we, force_we}));

  assert_force_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    force_we |=> ($stable(seg_rd) && $stable(seg_wr)));

endmodule

// File: tb/bank_pager_tb.sv
module bank_pager_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_port = 8'h00;
  logic [7:0]  io_data = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic [6:0]  rd_bank, wr_bank;
  logic [20:0] rd_paddr, wr_paddr;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int  m_rd [4];
  int  m_wr [4];
  bit  m_frc [4];

  always #5 clk = ~clk;

  bank_pager u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
    .io_data(io_data), .cpu_addr(cpu_addr), .rd_bank(rd_bank),
    .wr_bank(wr_bank), .rd_paddr(rd_paddr), .wr_paddr(wr_paddr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_rd[i] = 0; m_wr[i] = 0; m_frc[i] = 1'b0;
      end
    end else if (io_wr) begin
      if (io_port >= 8'hF0 && io_port <= 8'hF3) begin
        int s;
        s = int'(io_port) - 'hF0;
        if (io_data[7]) begin
          m_rd[s] = int'(io_data[6:0]); m_wr[s] = int'(io_data[6:0]);
        end else begin
          m_rd[s] = int'(io_data[6:4]); m_wr[s] = int'(io_data[2:0]);
        end
      end else if (io_port == 8'hF4) begin
        m_frc[3] = io_data[7]; m_frc[0] = io_data[6];
        m_frc[2] = io_data[5]; m_frc[1] = io_data[4];
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int s, er, ew;
    s  = int'(cpu_addr[15:14]);
    ew = m_wr[s];
    er = m_frc[s] ? m_wr[s] : m_rd[s];
    check(tag, int'(rd_bank), er);
    check(tag, int'(wr_bank), ew);
    check("R7", int'(rd_paddr), (er << 14) | int'(cpu_addr[13:0]));
    check("R7", int'(wr_paddr), (ew << 14) | int'(cpu_addr[13:0]));
  endtask

  // drive on the falling edge, compare 1 ns later
  task automatic step(input string tag, input logic wr, input logic [7:0] port,
                      input logic [7:0] data, input logic [15:0] addr);
    @(negedge clk);
    io_wr = wr; io_port = port; io_data = data; cpu_addr = addr;
    #1 compare(tag);
  endtask

  task automatic peek_all(input string tag);
    for (int s = 0; s < 4; s++) step(tag, 1'b0, 8'h00, 8'h00, 16'(s * 'h4000 + 'h123));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    peek_all("R1");

    // R3: unified mapping, the documented example and the top value
    step("R3", 1'b1, 8'hF1, 8'h85, 16'h4000);
    step("R9", 1'b0, 8'h00, 8'h00, 16'h4ABC);
    check("R3", int'(rd_bank), 5);
    check("R3", int'(wr_bank), 5);
    step("R3", 1'b1, 8'hF3, 8'h87, 16'hC000);
    step("R3", 1'b1, 8'hF2, 8'hFF, 16'h8001);
    step("R3", 1'b1, 8'hF0, 8'hA1, 16'h3FFF);
    peek_all("R2");
    check("R3", int'(wr_bank), 7);

    // R4: split read/write with bit 3 set and clear
    step("R4", 1'b1, 8'hF0, 8'h5A, 16'h0010);
    step("R4", 1'b0, 8'h00, 8'h00, 16'h0010);
    check("R4", int'(rd_bank), 5);
    check("R4", int'(wr_bank), 2);
    step("R4", 1'b1, 8'hF2, 8'h73, 16'h8000);
    step("R4", 1'b0, 8'h00, 8'h00, 16'hBFFF);
    check("R4", int'(rd_bank), 7);
    check("R4", int'(wr_bank), 3);

    // R9: old mapping visible while strobe is pending, new one after
    step("R9", 1'b1, 8'hF0, 8'h86, 16'h0000);
    check("R9", int'(rd_bank), 5);
    step("R9", 1'b0, 8'h00, 8'h00, 16'h0000);
    check("R9", int'(rd_bank), 6);
    step("R4", 1'b1, 8'hF0, 8'h5A, 16'h0000);

    // R5/R6: force flags one at a time, low nibble set as noise
    for (int b = 4; b < 8; b++) begin
      step("R5", 1'b1, 8'hF4, 8'((1 << b) | 'h0F), 16'h0000);
      peek_all("R6");
    end
    step("R6", 1'b1, 8'hF4, 8'h40, 16'h0000);
    step("R6", 1'b0, 8'h00, 8'h00, 16'h0000);
    check("R6", int'(rd_bank), 2);
    check("R6", int'(wr_bank), 2);
    step("R6", 1'b1, 8'hF4, 8'h00, 16'h0000);
    step("R6", 1'b0, 8'h00, 8'h00, 16'h0000);
    check("R6", int'(rd_bank), 5);

    // R8: no strobe, and strobes to foreign ports
    step("R8", 1'b0, 8'hF0, 8'h81, 16'h0000);
    step("R8", 1'b1, 8'hF5, 8'h81, 16'h0000);
    step("R8", 1'b1, 8'hEF, 8'hF0, 16'h0000);
    step("R8", 1'b1, 8'hF8, 8'hFF, 16'h0000);
    peek_all("R8");
    check("R8", int'(wr_bank), 7);

    // R2: random mix of live and ignored writes
    for (int i = 0; i < 400; i++) begin
      logic [7:0] p;
      p = ($urandom_range(0, 9) < 8) ? 8'(8'hF0 + $urandom_range(0, 5)) : 8'($urandom);
      step("R2", 1'($urandom), p, 8'($urandom), 16'($urandom));
    end
    peek_all("R2");

    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1 compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    peek_all("R1");

    finish_run();
  end

endmodule